// File: doc/BRIEF.md
# Next-Address Unit with Jump, Branch and Subroutine Link

This block produces the program counter of a small fetch-execute processor. Every instruction step takes two clock cycles, driven by a two-state controller. In the fetch state (`ST_FETCH`) the unit stores the fall-through address, the program counter plus the fixed instruction length of 4 bytes, in an internal next-address register. In the execute state (`ST_EXEC`) it samples a 3-bit control operation, an operand and a taken flag. It then rewrites the next-address value as a jump, a relative branch, a call or a return, and copies the result into the program counter at the end of that cycle.

The controller moves from `ST_FETCH` to `ST_EXEC` unconditionally, which is transition T1. It moves from `ST_EXEC` back to `ST_FETCH` unconditionally, which is transition T2 and closes the step. Reset puts the controller in `ST_FETCH` and loads the start address into both the program counter and the single link register. The surrounding decoder watches `accept_o` and presents the operation of the current instruction while it is high.

Top module: `nau_top`

## Requirements
- R1: After reset, `pc_o` equals `START_ADDR` (default 0x0000_1000), `accept_o` is low, and the link register holds `START_ADDR`.
- R2: `accept_o` is high in every second cycle after reset, beginning with the second cycle. `pc_o` changes only at the clock edge that ends a cycle in which `accept_o` was high.
- R3: Operation code 000 (sequential) sets `pc_o` to the old `pc_o` plus 4.
- R4: Operation code 001 (jump) sets `pc_o` to `operand_i`.
- R5: Operation code 010 (branch) with `taken_i` high sets `pc_o` to the old `pc_o` plus 4 plus `operand_i`. The operand is read as a two's-complement value and the sum wraps modulo 2^AW.
- R6: Operation code 010 with `taken_i` low sets `pc_o` to the old `pc_o` plus 4.
- R7: Operation code 011 (call) sets `pc_o` to `operand_i` and stores the old `pc_o` plus 4 in the link register.
- R8: Operation code 100 (return) sets `pc_o` to the value held in the link register.
- R9: A second call overwrites the link register. A return with no call since reset goes to `START_ADDR`.
- R10: Operation codes 101, 110 and 111 behave as sequential. `taken_i` has no effect on any operation other than branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Control operation, sampled while `accept_o` is high |
| operand_i | input | AW | Jump or call target, or signed branch offset |
| taken_i | input | 1 | Branch condition |
| pc_o | output | AW | Program counter |
| accept_o | output | 1 | High in the execute cycle of each step |

## Verification
Two things happen at the same clock edge during a call step: the link register is written and the program counter is redirected. A return placed directly after a call then reads the link value that was written only one step earlier. The bench provokes this with directed call-return pairs, with nested calls, and with random operation sequences that often place a return directly after a call. A reference model tracks the program counter and link register independently, and the bench compares `pc_o` against that model after every step. Branches whose offset wraps across address zero and returns issued before any call cover the boundaries of the address arithmetic and of the link reset value.

// File: rtl/nau_pkg.sv
package nau_pkg;
    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JMP  = 3'd1,
        OP_BR   = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } nau_op_e;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } nau_st_e;
endpackage

// File: rtl/nau_seq_fsm.sv
module nau_seq_fsm
    import nau_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    output nau_st_e state,
    output logic    accept
);
    nau_st_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_FETCH;
        accept   = 1'b0;
        unique case (state)
            ST_FETCH: begin
                state_nx = ST_EXEC;   // T1
            end
            ST_EXEC: begin
                state_nx = ST_FETCH;  // T2
                accept   = 1'b1;
            end
            default: state_nx = ST_FETCH;
        endcase
    end

    // R2: execute cycle never repeats back to back
    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> accept);
endmodule

// File: rtl/nau_target_mux.sv
module nau_target_mux
    import nau_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    op,
    input  logic [AW-1:0] operand,
    input  logic          taken,
    input  logic [AW-1:0] fall,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] target,
    output logic          save_link
);
    always_comb begin
        target    = fall;
        save_link = 1'b0;
        case (op)
            OP_JMP:  target = operand;
            OP_BR:   target = taken ? fall + operand : fall;
            OP_CALL: begin
                target    = operand;
                save_link = 1'b1;
            end
            OP_RET:  target = link;
            default: target = fall;   // R10: spare codes fall through
        endcase
    end
endmodule

// File: rtl/nau_link_reg.sv
module nau_link_reg #(
    parameter int          AW         = 32,
    parameter logic [AW-1:0] START_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [AW-1:0] save_val,
    output logic [AW-1:0] link
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       link <= START_ADDR;
        else if (save_en) link <= save_val;
    end

    // R7: a call stores the return address
    a_r7_link_capture: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> link == $past(save_val));
    // R9: link only moves on a call
    a_r9_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !save_en |=> $stable(link));
endmodule

// File: rtl/nau_top.sv
module nau_top
    import nau_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            ILEN       = 4,
    parameter logic [AW-1:0] START_ADDR = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] operand_i,
    input  logic          taken_i,
    output logic [AW-1:0] pc_o,
    output logic          accept_o
);
    localparam logic [AW-1:0] STEP = AW'(ILEN);

    nau_st_e       state;
    logic [AW-1:0] nar;
    logic [AW-1:0] link;
    logic [AW-1:0] target;
    logic          save_link;
    logic          exec_cycle;

    nau_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .accept (exec_cycle)
    );

    nau_target_mux #(.AW(AW)) u_mux (
        .op        (op_i),
        .operand   (operand_i),
        .taken     (taken_i),
        .fall      (nar),
        .link      (link),
        .target    (target),
        .save_link (save_link)
    );

    nau_link_reg #(.AW(AW), .START_ADDR(START_ADDR)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (save_link && exec_cycle),
        .save_val (nar),
        .link     (link)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_o <= START_ADDR;
            nar  <= START_ADDR;
        end else begin
            unique case (state)
                ST_FETCH: nar  <= pc_o + STEP;
                ST_EXEC:  pc_o <= target;
                default:  nar  <= nar;
            endcase
        end
    end

    assign accept_o = exec_cycle;

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |=> $stable(pc_o));
    a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && op_i == 3'd0) |=> pc_o == $past(pc_o) + STEP);
    a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && op_i == 3'd1) |=> pc_o == $past(operand_i));
    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && op_i == 3'd4) |=> pc_o == $past(link));
endmodule

// File: tb/nau_top_tb.sv
module nau_top_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam logic [31:0] START      = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic [AW-1:0] operand_i = '0;
    logic          taken_i = 1'b0;
    logic [AW-1:0] pc_o;
    logic          accept_o;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_link;

    nau_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .operand_i (operand_i),
        .taken_i   (taken_i),
        .pc_o      (pc_o),
        .accept_o  (accept_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] model_next(input logic [2:0] op,
        input logic [AW-1:0] opnd, input logic tk,
        input logic [AW-1:0] pc, input logic [AW-1:0] lnk);
        logic [AW-1:0] fall;
        fall = pc + 32'd4;
        case (op)
            3'd1: return opnd;
            3'd2: return tk ? fall + opnd : fall;
            3'd3: return opnd;
            3'd4: return lnk;
            default: return fall;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic tk);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return tk ? "R5" : "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Entered at a negedge in the fetch cycle; returns at the next fetch negedge.
    task automatic do_step(input logic [2:0] op, input logic [AW-1:0] opnd,
                           input logic tk, input string req);
        logic [AW-1:0] exp;
        check("R2 fetch accept", {31'd0, accept_o}, 32'd0);
        check("R2 pc hold", pc_o, m_pc);
        @(negedge clk);
        check("R2 exec accept", {31'd0, accept_o}, 32'd1);
        op_i = op; operand_i = opnd; taken_i = tk;
        exp = model_next(op, opnd, tk, m_pc, m_link);
        if (op == 3'd3) m_link = m_pc + 32'd4;
        m_pc = exp;
        @(negedge clk);
        check(req, pc_o, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_pc = START;
        m_link = START;
        repeat (3) @(negedge clk);
        check("R1 reset pc", pc_o, START);
        rst_n = 1'b1;
        check("R1 reset accept", {31'd0, accept_o}, 32'd0);
        // R9: return before any call lands on the start address
        do_step(3'd4, 32'h0, 1'b0, "R9 return without call");
        do_step(3'd0, 32'h0, 1'b1, "R10 taken ignored on sequential");
        do_step(3'd1, 32'h0000_0000, 1'b1, "R4 jump to zero");
        do_step(3'd2, 32'hFFFF_FFF8, 1'b1, "R5 branch wraps below zero");
        do_step(3'd2, 32'h0000_0100, 1'b0, "R6 branch not taken");
        do_step(3'd3, 32'h0000_2000, 1'b0, "R7 first call");
        do_step(3'd3, 32'h0000_3000, 1'b0, "R9 nested call overwrites");
        do_step(3'd4, 32'h0, 1'b0, "R9 return to latest caller");
        do_step(3'd4, 32'h0, 1'b1, "R8 second return reuses link");
        do_step(3'd5, 32'h0000_5555, 1'b1, "R10 code 101");
        do_step(3'd6, 32'h0000_5555, 1'b0, "R10 code 110");
        do_step(3'd7, 32'h0000_5555, 1'b1, "R10 code 111");
        do_step(3'd3, 32'h0000_4000, 1'b1, "R7 call then return");
        do_step(3'd4, 32'h0, 1'b0, "R8 return right after call");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] rop;
            logic [AW-1:0] ropnd;
            logic rtk;
            rop   = 3'($urandom % 8);
            ropnd = $urandom;
            if (rop == 3'd2) ropnd = 32'($signed(16'($urandom)));
            rtk   = 1'($urandom);
            do_step(rop, ropnd, rtk, tag_of(rop, rtk));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule